// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Private Result Pair

This unit performs 32-bit integer multiplication and division for a simple in-order pipeline. A start command carries a two-bit opcode and two operands. The unit then works on its own for a fixed number of cycles. At the end it commits both result words in one edge to a private pair of result registers, a high word and a low word. It never writes the general register file, so it never contends with single-cycle ALU or load results for a write port.

Two read ports expose the stored high and low words at all times. The pipeline issues its move-from-high and move-from-low operations through these ports and writes the value back through its normal path. The unit has no interlock. A read made while an operation is still running returns whatever the pair held before. Software must allow for the latency.

Multiplication uses one shift-add step per cycle. Division uses one restoring subtract step per cycle. Signed modes work on magnitudes, and the signs are corrected at commit.

Top module: `muldiv_hilo`

## Requirements
- R1: `op_i[1]` selects the operation (0 multiply, 1 divide) and `op_i[0]` selects signedness (1 two's-complement signed, 0 unsigned). The same operands give different results in signed and unsigned modes.
- R2: A multiply commits the full 64-bit product, with bits 31:0 on `lo_o` and bits 63:32 on `hi_o`.
- R3: A divide with a nonzero divisor commits the quotient, truncated toward zero, to `lo_o` and the remainder, carrying the sign of the dividend, to `hi_o`. A signed most-negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R4: `start_i` is sampled only while `busy_o` is low. `busy_o` goes high at the edge that samples it, stays high for 33 cycles, and falls at the edge that commits the results.
- R5: `hi_o` and `lo_o` change only at a commit edge (or reset), and both change at that same edge.
- R6: There is no interlock. While an operation runs, `hi_o` and `lo_o` keep showing the previously committed values.
- R7: A divide by zero completes in the normal 33 cycles and commits all ones to `lo_o` and the unmodified dividend to `hi_o`.
- R8: A start command, opcode or operand change while `busy_o` is high is ignored. Neither the timing nor the result of the running operation changes.
- R9: Reset (active low) clears `hi_o`, `lo_o` and `busy_o`, including in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| start_i | input | 1 | Start command, taken when idle |
| op_i | input | 2 | Opcode: bit 1 divide, bit 0 signed |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High from the accepting edge until commit |
| hi_o | output | 32 | Move-from-high read port |
| lo_o | output | 32 | Move-from-low read port |

## Verification
The products tried are small, all-ones unsigned, mixed-sign signed and most-negative squared. Together they separate a wrong half placement from a missing carry and from a wrong sign fix-up. The divides cover every sign combination, the most-negative by -1 overflow case and a zero divisor. These separate the truncation direction, the remainder sign and the zero-divisor override. One run changes the start, opcode and operands during an operation, and another resets in the middle of an operation. A behavioural model compares busy, high and low on every cycle, which exposes any off-by-one in latency and any early update of the pair.

// File: rtl/md_pkg.sv
package md_pkg;
  // bit 1: divide, bit 0: signed
  typedef enum logic [1:0] {
    MD_MULU = 2'b00,
    MD_MULS = 2'b01,
    MD_DIVU = 2'b10,
    MD_DIVS = 2'b11
  } md_op_e;

  function automatic logic is_div(md_op_e op);
    return op[1];
  endfunction

  function automatic logic is_signed(md_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  logic [W-1:0]   mcand_q, mcand_d;
  logic [2*W-1:0] acc_q, acc_d;
  logic [W:0]     sum;
  logic           en;

  // one shift-add step: add multiplicand into the upper half when the
  // current multiplier bit is set, then shift the whole accumulator right
  always_comb begin
    sum     = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    mcand_d = mcand_q;
    acc_d   = acc_q;
    if (load_i) begin
      mcand_d = mcand_i;
      acc_d   = {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      acc_d   = {sum, acc_q[W-1:1]};
    end
  end

  assign en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
    end else if (en) begin
      mcand_q <= mcand_d;
      acc_q   <= acc_d;
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] dvs_q, dvs_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] rem_q, rem_d;
  logic [W:0]   shifted;
  logic [W-1:0] trial;
  logic         fits;
  logic         en;

  // restoring step: bring in the next dividend bit, try the subtract,
  // keep it only when the partial remainder covers the divisor
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = shifted >= {1'b0, dvs_q};
    trial   = shifted[W-1:0] - dvs_q;
    dvs_d   = dvs_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    if (load_i) begin
      dvs_d = dvs_i;
      quo_d = dvd_i;
      rem_d = '0;
    end else if (step_i) begin
      quo_d = {quo_q[W-2:0], fits};
      rem_d = fits ? trial : shifted[W-1:0];
    end
  end

  assign en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
    end else if (en) begin
      dvs_q <= dvs_d;
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_q != '0) |-> (rem_q < dvs_q)); // R3
endmodule

// File: rtl/md_hilo.sv
module md_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] hi_d_i,
  input  logic [W-1:0] lo_d_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] hi_q, lo_q;

  // one enable for both words: they always commit at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (we_i) begin
      hi_q <= hi_d_i;
      lo_q <= lo_d_i;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  AST_PAIR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_q != $past(hi_q)) || (lo_q != $past(lo_q))) |-> $past(we_i)); // R5
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  md_op_e        op_q, op_d;
  logic          nega_q, nega_d;
  logic          negb_q, negb_d;
  logic          dz_q, dz_d;
  logic [W-1:0]  dvd_q, dvd_d;

  logic          accept, commit, step;
  logic          sgn_in;
  logic [W-1:0]  mag_a, mag_b;
  logic [2*W-1:0] prod;
  logic [W-1:0]  quo, rem;
  logic [2*W-1:0] prod_fix;
  logic [W-1:0]  quo_fix, rem_fix;
  logic [W-1:0]  hi_d, lo_d;

  assign accept = start_i & ~busy_q;
  assign commit = busy_q & (cnt_q == LAST);
  assign step   = busy_q & ~commit;

  // operand magnitudes for the cores
  assign sgn_in = op_i[0];
  assign mag_a  = (sgn_in && opa_i[W-1]) ? (~opa_i + 1'b1) : opa_i;
  assign mag_b  = (sgn_in && opb_i[W-1]) ? (~opb_i + 1'b1) : opb_i;

  // sequencer next state
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    nega_d = nega_q;
    negb_d = negb_q;
    dz_d   = dz_q;
    dvd_d  = dvd_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      op_d   = md_op_e'(op_i);
      nega_d = sgn_in & opa_i[W-1];
      negb_d = sgn_in & opb_i[W-1];
      dz_d   = (opb_i == '0);
      dvd_d  = opa_i;
    end else if (commit) begin
      busy_d = 1'b0;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= MD_MULU;
      nega_q <= 1'b0;
      negb_q <= 1'b0;
      dz_q   <= 1'b0;
      dvd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (accept) begin
        op_q   <= op_d;
        nega_q <= nega_d;
        negb_q <= negb_d;
        dz_q   <= dz_d;
        dvd_q  <= dvd_d;
      end
    end
  end

  md_mul_core #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (accept),
    .step_i   (step & ~is_div(op_q)),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .prod_o   (prod)
  );

  md_div_core #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .step_i (step & is_div(op_q)),
    .dvd_i  (mag_a),
    .dvs_i  (mag_b),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  // sign correction and result selection at commit
  always_comb begin
    prod_fix = (is_signed(op_q) && (nega_q ^ negb_q)) ? (~prod + 1'b1) : prod;
    quo_fix  = (is_signed(op_q) && (nega_q ^ negb_q)) ? (~quo + 1'b1) : quo;
    rem_fix  = (is_signed(op_q) && nega_q) ? (~rem + 1'b1) : rem;
    if (!is_div(op_q)) begin
      hi_d = prod_fix[2*W-1:W];
      lo_d = prod_fix[W-1:0];
    end else if (dz_q) begin
      hi_d = dvd_q;
      lo_d = '1;
    end else begin
      hi_d = rem_fix;
      lo_d = quo_fix;
    end
  end

  md_hilo #(.W(W)) u_hilo (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (commit),
    .hi_d_i (hi_d),
    .lo_d_i (lo_d),
    .hi_o   (hi_o),
    .lo_o   (lo_o)
  );

  assign busy_o = busy_q;

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i)); // R4

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != LAST)) |=> busy_q); // R4

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q == LAST)) |=> !busy_q); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(op_q) && $stable(dvd_q))); // R8

  AST_DIVZERO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && is_div(op_q) && dz_q) |-> ((lo_o == '1) && (hi_o == dvd_q))); // R7
endmodule

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        busy_o;
  logic [31:0] hi_o, lo_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  muldiv_hilo uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .opa_i(a), .opb_i(b), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  // behavioural reference: results from wide integer arithmetic
  function automatic void ref_calc(input logic [1:0] o, input logic [31:0] x, y,
                                   output logic [31:0] rh, output logic [31:0] rl);
    longint sp;
    longint unsigned up;
    longint sx, sy, q, r;
    if (!o[1]) begin
      if (o[0]) begin
        sp = longint'($signed(x)) * longint'($signed(y));
        rh = sp[63:32]; rl = sp[31:0];
      end else begin
        up = {32'b0, x} * {32'b0, y};
        rh = up[63:32]; rl = up[31:0];
      end
    end else if (y == 32'b0) begin
      rh = x; rl = 32'hFFFF_FFFF;
    end else if (o[0]) begin
      sx = longint'($signed(x)); sy = longint'($signed(y));
      q = sx / sy; r = sx % sy;
      rh = r[31:0]; rl = q[31:0];
    end else begin
      rh = x % y; rl = x / y;
    end
  endfunction

  // cycle-by-cycle model state
  logic        m_busy;
  int          m_cnt;
  logic [31:0] m_hi, m_lo, p_hi, p_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_cnt = 0; m_hi = '0; m_lo = '0;
    end else if (m_busy) begin
      if (m_cnt == 32) begin
        m_busy = 1'b0; m_hi = p_hi; m_lo = p_lo;
      end else m_cnt++;
    end else if (start) begin
      m_busy = 1'b1; m_cnt = 0;
      ref_calc(op, a, b, p_hi, p_lo);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(busy_o === m_busy, "R4", "busy per cycle", {31'b0, busy_o}, {31'b0, m_busy});
      check(hi_o === m_hi, "R5", "hi per cycle", hi_o, m_hi);
      check(lo_o === m_lo, "R5", "lo per cycle", lo_o, m_lo);
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [31:0] x, y,
                        input string req, input bit poke);
    logic [31:0] eh, el, oh, ol;
    ref_calc(o, x, y, eh, el);
    @(negedge clk);
    oh = hi_o; ol = lo_o;
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    check(busy_o === 1'b1, "R4", "busy after start", {31'b0, busy_o}, 32'd1);
    for (int i = 0; i < 32; i++) begin
      if (poke && i < 4) begin
        start = 1'b1; op = ~o; a = ~x; b = y + 32'd3;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(busy_o === 1'b1, "R4", "busy before commit", {31'b0, busy_o}, 32'd1);
    check(hi_o === oh, "R6", "old hi while busy", hi_o, oh);
    check(lo_o === ol, "R6", "old lo while busy", lo_o, ol);
    @(negedge clk);
    check(busy_o === 1'b0, "R4", "busy low at commit", {31'b0, busy_o}, 32'd0);
    check(hi_o === eh, req, "hi result", hi_o, eh);
    check(lo_o === el, req, "lo result", lo_o, el);
  endtask

  initial begin
    logic [31:0] u_lo;
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0, "R9", "busy in reset", {31'b0, busy_o}, 32'd0);
    check(hi_o === 32'd0, "R9", "hi in reset", hi_o, 32'd0);
    check(lo_o === 32'd0, "R9", "lo in reset", lo_o, 32'd0);
    rst_n = 1'b1;
    run_op(2'b00, 32'd7, 32'd9, "R2", 1'b0);
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 1'b0);
    run_op(2'b01, 32'hFFFF_FFFD, 32'd5, "R2", 1'b0);
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000, "R2", 1'b0);
    // R1: same operands, unsigned then signed, must differ
    run_op(2'b00, 32'hFFFF_FFFF, 32'd2, "R1", 1'b0);
    u_lo = hi_o;
    run_op(2'b01, 32'hFFFF_FFFF, 32'd2, "R1", 1'b0);
    check(hi_o !== u_lo, "R1", "signed hi differs from unsigned", hi_o, ~u_lo);
    run_op(2'b10, 32'd100, 32'd7, "R3", 1'b0);
    run_op(2'b11, 32'hFFFF_FF9C, 32'd7, "R3", 1'b0);
    run_op(2'b11, 32'd100, 32'hFFFF_FFF9, "R3", 1'b0);
    run_op(2'b11, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R3", 1'b0);
    run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, "R3", 1'b0);
    check(lo_o === 32'h8000_0000, "R3", "min by -1 quotient", lo_o, 32'h8000_0000);
    run_op(2'b10, 32'hFFFF_FFFF, 32'd1, "R3", 1'b0);
    run_op(2'b11, 32'hFFFF_FFFB, 32'd0, "R7", 1'b0);
    check(lo_o === 32'hFFFF_FFFF, "R7", "zero divisor lo", lo_o, 32'hFFFF_FFFF);
    check(hi_o === 32'hFFFF_FFFB, "R7", "zero divisor hi", hi_o, 32'hFFFF_FFFB);
    run_op(2'b10, 32'd12345, 32'd0, "R7", 1'b0);
    run_op(2'b01, 32'd1000, 32'hFFFF_FF00, "R8", 1'b1);
    run_op(2'b10, 32'd99999, 32'd10, "R8", 1'b1);
    // R9: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; op = 2'b00; a = 32'd3; b = 32'd3;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b0, "R9", "busy after reset", {31'b0, busy_o}, 32'd0);
    check(hi_o === 32'd0, "R9", "hi after reset", hi_o, 32'd0);
    check(lo_o === 32'd0, "R9", "lo after reset", lo_o, 32'd0);
    rst_n = 1'b1;
    run_op(2'b11, 32'd50, 32'hFFFF_FFFA, "R3", 1'b0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule